// File: doc/BRIEF.md
# Command List Register Writer

The block holds a bank of 32-bit configuration registers. Each write into the bank merges the new word with the old contents under a byte-lane mask. Registers can be written in two ways. The first is directly, over a simple register bus that decodes a fixed address window. The second is indirectly, by a fetch engine that walks a command list held in memory. The engine reads the list one word at a time through a request/valid memory port, so any memory latency is tolerated.

A list is started by writing a nonzero word to one of two trigger registers. Each trigger register has its own address register and its own size register. Every command in the list is made of the following words, in this order:

- a first parameter word;
- a header naming the target register, a byte-lane select, a count of extra parameters and an index-stepping mode;
- the extra parameter words.

Each command is padded to an 8-byte boundary. A list can start another list, or restart itself, by writing a trigger register.

Top module: `cmdl_proc`

## Requirements
- R1: A write to trigger register 12 (buffer 0) or trigger register 13 (buffer 1) starts that buffer when the raw written word is nonzero. A word of zero starts nothing, and the busy output stays low.
- R2: The start byte address is bits [27:0] of register 8 (buffer 0) or register 9 (buffer 1), shifted left by 3. The list length in bytes is bits [19:0] of register 10 or register 11, shifted left by 3. A length of zero starts no fetch.
- R3: Each command is read as two words: first the parameter word, then the header. In the header, bits [15:0] are the target index, bits [19:16] are the byte-lane select, bits [27:20] are the number of extra parameter words, and bit 31 is the stepping mode.
- R4: Select bit k enables register bits [8k+7:8k]. Every register update stores (old & ~mask) | (word & mask).
- R5: When header bit 31 is 1, the target index increases by one after each write. When it is 0, every parameter of the command goes to the same register.
- R6: After a command, the read pointer is rounded up to a multiple of 8 bytes. Fetching stops at a command boundary once the pointer is at or past start + length.
- R7: A bus write at an address A with 0x1EF01000 <= A < 0x1EF01C00 writes register (A - 0x1EF01000)/4 with all bytes enabled. A bus write outside this window is ignored. A bus read returns that register, or 0 if A is outside the window.
- R8: Any write, from the bus or from a list, to an index at or above NUM_REGS changes no register. Reads of such indices return 0.
- R9: A list word that writes a nonzero value to a trigger register abandons the rest of the current list and fetches the selected buffer next.
- R10: A nonzero bus write to a trigger register while a list is running restarts fetching at the selected buffer.
- R11: mem_req_o stays high with a stable, word-aligned mem_addr_o until mem_rvalid_i is returned. One list word is consumed per valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_addr_i | input | 32 | Register bus byte address (write and read) |
| bus_wdata_i | input | 32 | Register bus write data |
| bus_rdata_o | output | 32 | Register bus read data, combinational |
| mem_req_o | output | 1 | List word request |
| mem_addr_o | output | 32 | List word byte address |
| mem_rvalid_i | input | 1 | Read word valid; completes the request |
| mem_rdata_i | input | 32 | Read word |
| busy_o | output | 1 | A list is being fetched |

## Verification
The bench builds the block with its defaults:

- NUM_REGS = 64;
- address registers at 8 and 9;
- size registers at 10 and 11;
- triggers at 12 and 13.

Because the bank is small, index 100 and window reads past index 63 exercise the discard path.

The bench memory's latency changes between runs, taking the values 0, 1 and 3. Latency 0 gives back-to-back valid cycles. Latency 3 leaves a long waiting window, so a bus trigger can land in the middle of a request. The list layouts cover both stepping modes, odd extra-word counts that need padding, a self-issued trigger, and a command placed just past the list end.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned IDXW = 16;
  localparam int unsigned LANES = DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_P0   = 2'd1,
    ST_HDR  = 2'd2,
    ST_PAR  = 2'd3
  } cmdl_state_e;

  typedef struct packed {
    logic            en;
    logic [IDXW-1:0] idx;
    logic [DW-1:0]   data;
    logic [DW-1:0]   mask;
  } cmdl_wr_t;
endpackage

// File: rtl/cmdl_byte_mask.sv
module cmdl_byte_mask #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0]   sel_i,
  output logic [LANES*8-1:0] mask_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask_o[g*8 +: 8] = {8{sel_i[g]}};
  end
endmodule

// File: rtl/cmdl_bus_dec.sv
module cmdl_bus_dec #(
  parameter logic [31:0] BASE = 32'h1EF0_1000,
  parameter logic [31:0] SPAN = 32'h0000_0C00
) (
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [15:0] idx_o
);
  localparam logic [31:0] LIMIT = BASE + SPAN;
  logic [31:0] off;

  assign off   = addr_i - BASE;
  assign hit_o = (addr_i >= BASE) && (addr_i < LIMIT);
  assign idx_o = 16'(off >> 2);
endmodule

// File: rtl/cmdl_regfile.sv
module cmdl_regfile
  import cmdl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  cmdl_wr_t                    bus_wr_i,
  input  cmdl_wr_t                    lst_wr_i,
  input  logic [IDXW-1:0]             rd_idx_i,
  output logic [DW-1:0]               rd_data_o,
  output logic [NUM_REGS-1:0][DW-1:0] regs_o
);
  localparam int unsigned AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  // bus write lands first, list write is layered on top
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] r_q, a_v, b_v;
    always_comb begin
      a_v = r_q;
      if (bus_wr_i.en && bus_wr_i.idx == IDXW'(g))
        a_v = (r_q & ~bus_wr_i.mask) | (bus_wr_i.data & bus_wr_i.mask);
      b_v = a_v;
      if (lst_wr_i.en && lst_wr_i.idx == IDXW'(g))
        b_v = (a_v & ~lst_wr_i.mask) | (lst_wr_i.data & lst_wr_i.mask);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else         r_q <= b_v;
    end
    assign regs_o[g] = r_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_idx_i < IDXW'(NUM_REGS)) rd_data_o = regs_o[rd_idx_i[AW-1:0]];
  end
endmodule

// File: rtl/cmdl_engine.sv
module cmdl_engine
  import cmdl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     start_addr_i,
  input  logic [31:0]     start_len_i,
  output logic            mem_req_o,
  output logic [31:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [LANES-1:0] wr_sel_o,
  output logic            busy_o
);
  cmdl_state_e      state_q;
  logic [31:0]      ptr_q, end_q, ptr_nx, ptr_al;
  logic [DW-1:0]    p0_q;
  logic [IDXW-1:0]  idx_q;
  logic             inc_q;
  logic [LANES-1:0] sel_q;
  logic [7:0]       rem_q;
  logic             fin;

  logic [IDXW-1:0]  h_idx;
  logic [LANES-1:0] h_sel;
  logic [7:0]       h_cnt;
  logic             h_inc;

  assign h_idx = mem_rdata_i[15:0];
  assign h_sel = mem_rdata_i[19:16];
  assign h_cnt = mem_rdata_i[27:20];
  assign h_inc = mem_rdata_i[31];

  assign ptr_nx = ptr_q + 32'd4;
  assign ptr_al = (ptr_nx + 32'd7) & ~32'd7;
  assign fin    = ptr_al >= end_q;

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = ptr_q;

  assign wr_en_o   = mem_rvalid_i && (state_q == ST_HDR || state_q == ST_PAR);
  assign wr_idx_o  = (state_q == ST_HDR) ? h_idx : idx_q;
  assign wr_data_o = (state_q == ST_HDR) ? p0_q : mem_rdata_i;
  assign wr_sel_o  = (state_q == ST_HDR) ? h_sel : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      end_q   <= '0;
      p0_q    <= '0;
      idx_q   <= '0;
      inc_q   <= 1'b0;
      sel_q   <= '0;
      rem_q   <= '0;
    end else if (start_i) begin
      ptr_q   <= start_addr_i;
      end_q   <= start_addr_i + start_len_i;
      state_q <= (start_len_i == '0) ? ST_IDLE : ST_P0;
    end else if (mem_rvalid_i) begin
      unique case (state_q)
        ST_P0: begin
          p0_q    <= mem_rdata_i;
          ptr_q   <= ptr_nx;
          state_q <= ST_HDR;
        end
        ST_HDR: begin
          idx_q <= h_idx + IDXW'(h_inc);
          inc_q <= h_inc;
          sel_q <= h_sel;
          rem_q <= h_cnt;
          if (h_cnt == 8'd0) begin
            ptr_q   <= ptr_al;
            state_q <= fin ? ST_IDLE : ST_P0;
          end else begin
            ptr_q   <= ptr_nx;
            state_q <= ST_PAR;
          end
        end
        ST_PAR: begin
          idx_q <= idx_q + IDXW'(inc_q);
          rem_q <= rem_q - 8'd1;
          if (rem_q == 8'd1) begin
            ptr_q   <= ptr_al;
            state_q <= fin ? ST_IDLE : ST_P0;
          end else begin
            ptr_q <= ptr_nx;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmdl_proc.sv
module cmdl_proc
  import cmdl_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 64,
  parameter logic [31:0] BUS_BASE  = 32'h1EF0_1000,
  parameter logic [31:0] BUS_SPAN  = 32'h0000_0C00,
  parameter int unsigned ADDR0_IDX = 8,
  parameter int unsigned ADDR1_IDX = 9,
  parameter int unsigned LEN0_IDX  = 10,
  parameter int unsigned LEN1_IDX  = 11,
  parameter int unsigned TRIG0_IDX = 12,
  parameter int unsigned TRIG1_IDX = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [31:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        busy_o
);
  localparam logic [31:0] ADDR_KEEP = 32'h0FFF_FFFF;
  localparam logic [31:0] LEN_KEEP  = 32'h000F_FFFF;

  logic                        bus_hit;
  logic [IDXW-1:0]             bus_idx;
  logic [DW-1:0]               rf_rd;
  logic [NUM_REGS-1:0][DW-1:0] rf_q;
  cmdl_wr_t                    bus_wr, lst_wr;

  logic                        wr_en;
  logic [IDXW-1:0]             wr_idx;
  logic [DW-1:0]               wr_data;
  logic [LANES-1:0]            wr_sel;
  logic [DW-1:0]               wr_mask;

  logic                        lst_trig, bus_trig, start;
  logic                        lst_buf, bus_buf, buf_sel;
  logic [31:0]                 start_addr, start_len;

  cmdl_bus_dec #(.BASE(BUS_BASE), .SPAN(BUS_SPAN)) u_dec (
    .addr_i (bus_addr_i),
    .hit_o  (bus_hit),
    .idx_o  (bus_idx)
  );

  cmdl_byte_mask #(.LANES(LANES)) u_mask (
    .sel_i  (wr_sel),
    .mask_o (wr_mask)
  );

  always_comb begin
    bus_wr.en   = bus_we_i && bus_hit;
    bus_wr.idx  = bus_idx;
    bus_wr.data = bus_wdata_i;
    bus_wr.mask = '1;
    lst_wr.en   = wr_en;
    lst_wr.idx  = wr_idx;
    lst_wr.data = wr_data;
    lst_wr.mask = wr_mask;
  end

  cmdl_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_wr_i  (bus_wr),
    .lst_wr_i  (lst_wr),
    .rd_idx_i  (bus_idx),
    .rd_data_o (rf_rd),
    .regs_o    (rf_q)
  );

  assign bus_rdata_o = bus_hit ? rf_rd : '0;

  // trigger decode on the raw written word; list trigger wins over bus
  assign lst_trig = wr_en && (wr_idx == IDXW'(TRIG0_IDX) || wr_idx == IDXW'(TRIG1_IDX))
                    && (wr_data != '0);
  assign lst_buf  = (wr_idx == IDXW'(TRIG1_IDX));
  assign bus_trig = bus_wr.en && (bus_idx == IDXW'(TRIG0_IDX) || bus_idx == IDXW'(TRIG1_IDX))
                    && (bus_wdata_i != '0);
  assign bus_buf  = (bus_idx == IDXW'(TRIG1_IDX));
  assign start    = lst_trig || bus_trig;
  assign buf_sel  = lst_trig ? lst_buf : bus_buf;

  assign start_addr = ((buf_sel ? rf_q[ADDR1_IDX] : rf_q[ADDR0_IDX]) & ADDR_KEEP) << 3;
  assign start_len  = ((buf_sel ? rf_q[LEN1_IDX]  : rf_q[LEN0_IDX])  & LEN_KEEP)  << 3;

  cmdl_engine u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_addr_i (start_addr),
    .start_len_i  (start_len),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_data_o    (wr_data),
    .wr_sel_o     (wr_sel),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/cmdl_proc_chk.sv
module cmdl_proc_chk #(
  parameter int unsigned NUM_REGS  = 64,
  parameter logic [31:0] BUS_BASE  = 32'h1EF0_1000,
  parameter int unsigned TRIG0_IDX = 12
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        busy_o,
  input logic                        mem_req_o,
  input logic [31:0]                 mem_addr_o,
  input logic                        mem_rvalid_i,
  input logic                        bus_we_i,
  input logic [31:0]                 bus_addr_i,
  input logic [31:0]                 bus_wdata_i,
  input logic                        wr_en,
  input logic [NUM_REGS-1:0][31:0]   rf_q
);
  localparam logic [31:0] TRIG0_ADDR = BUS_BASE + 32'(TRIG0_IDX * 4);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && !bus_we_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R11
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R1
  zero_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && bus_we_i && bus_addr_i == TRIG0_ADDR && bus_wdata_i == 32'd0) |=> !busy_o);

  // R8
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_we_i && !wr_en) |=> $stable(rf_q));
endmodule

bind cmdl_proc cmdl_proc_chk #(
  .NUM_REGS(NUM_REGS), .BUS_BASE(BUS_BASE), .TRIG0_IDX(TRIG0_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .wr_en(wr_en), .rf_q(rf_q)
);

// File: tb/cmdl_proc_tb_top.sv
module cmdl_proc_tb_top;
  localparam logic [31:0] BASE = 32'h1EF0_1000;
  localparam int NREG = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = 32'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 1;
  int wait_cnt = 0;
  logic [31:0] mem [0:1023];

  always #4 clk = ~clk;

  cmdl_proc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .busy_o(busy)
  );

  // memory model
  assign mem_rvalid = mem_req && (wait_cnt >= lat);
  assign mem_rdata  = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    if (!mem_req || mem_rvalid) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(logic [3:0] s);
    logic [31:0] m = 0;
    for (int k = 0; k < 4; k++) if (s[k]) m |= 32'hFF << (8 * k);
    return m;
  endfunction

  function automatic logic [31:0] hdr(int idx, int sel, int cnt, bit seq);
    return {seq, 3'b000, 8'(cnt), 4'(sel), 16'(idx)};
  endfunction

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a < BASE + 32'hC00);
  endfunction

  // behavioural reference, evaluated mid-cycle for the coming edge
  int          ms = 0;
  logic [31:0] mptr, mend, mp0;
  int          midx, mrem;
  bit          minc;
  logic [3:0]  msel;
  logic [31:0] mregs [NREG];

  always @(negedge clk) begin
    if (!rst_n) begin
      ms = 0; mptr = 0; mend = 0;
      for (int i = 0; i < NREG; i++) mregs[i] = 0;
    end else begin
      bit lw, bw, trig;
      int lidx, bidx, tbuf;
      logic [31:0] ldat, lmask, rexp, saddr, slen, nptr;
      chk("R1 busy", 32'(busy), 32'(ms != 0));
      chk("R11 mem_req", 32'(mem_req), 32'(ms != 0));
      if (ms != 0) chk("R2 mem_addr", mem_addr, mptr);
      bidx = int'((bus_addr - BASE) >> 2);
      rexp = 0;
      if (in_win(bus_addr) && bidx < NREG) rexp = mregs[bidx];
      chk("R7 bus_rdata", bus_rdata, rexp);

      lw = 0; lidx = 0; ldat = 0; lmask = 0;
      if (mem_rvalid && ms == 2) begin
        lw = 1; lidx = int'(mem_rdata[15:0]); ldat = mp0; lmask = lane_mask(mem_rdata[19:16]);
      end else if (mem_rvalid && ms == 3) begin
        lw = 1; lidx = midx; ldat = mem_rdata; lmask = lane_mask(msel);
      end
      bw = bus_we && in_win(bus_addr);
      trig = 0; tbuf = 0;
      if (lw && (lidx == 12 || lidx == 13) && ldat != 0) begin
        trig = 1; tbuf = lidx - 12;
      end else if (bw && (bidx == 12 || bidx == 13) && bus_wdata != 0) begin
        trig = 1; tbuf = bidx - 12;
      end
      saddr = (mregs[8 + tbuf] & 32'h0FFFFFFF) << 3;
      slen  = (mregs[10 + tbuf] & 32'h000FFFFF) << 3;
      if (bw && bidx < NREG) mregs[bidx] = bus_wdata;
      if (lw && lidx < NREG) mregs[lidx] = (mregs[lidx] & ~lmask) | (ldat & lmask);

      if (trig) begin
        mptr = saddr; mend = saddr + slen; ms = (slen == 0) ? 0 : 1;
      end else if (mem_rvalid) begin
        nptr = mptr + 4;
        case (ms)
          1: begin mp0 = mem_rdata; mptr = nptr; ms = 2; end
          2: begin
            midx = int'(mem_rdata[15:0]) + int'(mem_rdata[31]);
            minc = mem_rdata[31]; msel = mem_rdata[19:16]; mrem = int'(mem_rdata[27:20]);
            if (mrem == 0) begin
              mptr = (nptr + 7) & ~32'd7; ms = (mptr >= mend) ? 0 : 1;
            end else begin mptr = nptr; ms = 3; end
          end
          3: begin
            midx = (midx + int'(minc)) & 16'hFFFF; mrem--;
            if (mrem == 0) begin
              mptr = (nptr + 7) & ~32'd7; ms = (mptr >= mend) ? 0 : 1;
            end else mptr = nptr;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic bus_write(int idx, logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = BASE + 32'(idx * 4); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic bus_write_raw(logic [31:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd_chk(string tag, logic [31:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(posedge clk); n++; end
    repeat (2) @(posedge clk);
  endtask

  task automatic put(int a, logic [31:0] w);
    mem[a >> 2] = w;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R11 reset req", 32'(mem_req), 0);

    // zero trigger and zero length
    bus_write(12, 0);
    @(negedge clk); chk("R1 zero trigger idle", 32'(busy), 0);
    bus_write(8, 32'h20); bus_write(10, 0); bus_write(12, 1);
    @(negedge clk); chk("R2 zero length idle", 32'(busy), 0);

    // main list, buffer 0 at 0x100, 0x40 bytes
    lat = 1;
    bus_write(24, 32'hAAAAAAAA); bus_write(25, 32'hAAAAAAAA);
    bus_write(26, 32'hAAAAAAAA); bus_write(30, 32'hFFFFFFFF);
    put(32'h100, 32'h11223344); put(32'h104, hdr(20, 4'hF, 0, 0));
    put(32'h108, 32'h12345678); put(32'h10C, hdr(24, 4'h5, 2, 1));
    put(32'h110, 32'h9ABCDEF0); put(32'h114, 32'h0F0F0F0F);
    put(32'h118, 32'h000000A1); put(32'h11C, hdr(30, 4'h9, 3, 0));
    put(32'h120, 32'h22000002); put(32'h124, 32'h33000003); put(32'h128, 32'h44000044);
    put(32'h12C, hdr(23, 4'hF, 0, 0));
    put(32'h130, 32'h55667788); put(32'h134, hdr(100, 4'hF, 0, 0));
    put(32'h138, 32'hCAFEF00D); put(32'h13C, hdr(21, 4'h2, 0, 0));
    put(32'h140, 32'h77777777); put(32'h144, hdr(22, 4'hF, 0, 0));
    bus_write(8, 32'h20); bus_write(10, 32'h8); bus_write(12, 32'h1);
    @(negedge clk); chk("R1 nonzero trigger busy", 32'(busy), 1);
    chk("R2 first fetch address", mem_addr, 32'h100);
    wait_idle();
    rd_chk("R3 first param to header index", BASE + 20 * 4, 32'h11223344);
    rd_chk("R4 byte lanes 0,2 r24", BASE + 24 * 4, 32'hAA34AA78);
    rd_chk("R5 stepping r25", BASE + 25 * 4, 32'hAABCAAF0);
    rd_chk("R5 stepping r26", BASE + 26 * 4, 32'hAA0FAA0F);
    rd_chk("R5 fixed target r30", BASE + 30 * 4, 32'h44FFFF44);
    rd_chk("R6 pad word not parsed r23", BASE + 23 * 4, 32'h0);
    rd_chk("R4 lane 1 after pad r21", BASE + 21 * 4, 32'h0000F000);
    rd_chk("R6 stop at list end r22", BASE + 22 * 4, 32'h0);
    rd_chk("R8 index 100 aliases nothing r36", BASE + 36 * 4, 32'h0);
    rd_chk("R8 read past bank", BASE + 100 * 4, 32'h0);

    // self retrigger, latency 0
    lat = 0;
    put(32'h200, 32'h5A5A5A5A); put(32'h204, hdr(41, 4'hF, 0, 0));
    put(32'h180, 32'h00000001); put(32'h184, hdr(13, 4'hF, 0, 0));
    put(32'h188, 32'h0BADBEEF); put(32'h18C, hdr(40, 4'hF, 0, 0));
    bus_write(9, 32'h40); bus_write(11, 32'h1);
    bus_write(8, 32'h30); bus_write(10, 32'h2); bus_write(12, 32'h1);
    wait_idle();
    rd_chk("R9 jumped buffer written r41", BASE + 41 * 4, 32'h5A5A5A5A);
    rd_chk("R9 abandoned command r40", BASE + 40 * 4, 32'h0);

    // bus trigger in the middle of a long list, latency 3
    lat = 3;
    put(32'h200, 32'h0000C0DE); put(32'h204, hdr(42, 4'hF, 0, 0));
    put(32'h300, 32'h1); put(32'h304, hdr(45, 4'hF, 20, 0));
    for (int i = 0; i < 20; i++) put(32'h308 + i * 4, 32'(i + 2));
    bus_write(8, 32'h60); bus_write(10, 32'd11); bus_write(12, 32'h1);
    repeat (12) @(posedge clk);
    bus_write(13, 32'h1);
    wait_idle();
    rd_chk("R10 restarted buffer r42", BASE + 42 * 4, 32'h0000C0DE);
    @(posedge clk); #1; bus_addr = BASE + 45 * 4;
    @(negedge clk);
    n_chk++;
    if (bus_rdata == 32'd21) begin
      n_fail++;
      $display("FAIL R10 long list not cut actual=%h expected<%h", bus_rdata, 32'd21);
    end

    // window edges
    bus_write_raw(BASE - 4, 32'hDEADBEEF);
    bus_write_raw(BASE + 32'hC00, 32'hFEEDFACE);
    rd_chk("R7 below window reads zero", BASE - 4, 32'h0);
    rd_chk("R7 above window no alias r0", BASE, 32'h0);
    rd_chk("R7 below window no alias r63", BASE + 63 * 4, 32'h0);
    bus_write(50, 32'h13579BDF);
    rd_chk("R7 full mask bus write", BASE + 50 * 4, 32'h13579BDF);

    repeat (4) @(posedge clk);
    summary();
  end
endmodule